// File: doc/BRIEF.md
# BCD/Binary Calendar Time Counter

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month, year and century. It advances once for every pulse on a one-second enable input. Each field is held and counted directly in the encoding the host selects, either packed BCD or plain binary. A second mode bit picks 24-hour hours or 12-hour hours, and in 12-hour mode bit 7 of the hours byte is the PM flag.

A host reaches every field through a byte-wide port at fixed addresses. Writes are synchronous and reads are combinational. A mode register holds a freeze bit, which stops counting while the host loads a new time, and the two encoding bits. A status register shows an update flag during the cycle in which an advance is pending.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the registers read as follows: seconds 0x00, minutes 0x00, hours 0x12 (12 AM), day of week 0x01, day of month 0x01, month 0x01, year 0x00, century 0x20, mode 0x00 and status 0x00.
- R2: Seconds sit at address 0x00, minutes at 0x02, hours at 0x04, day of week at 0x06, day of month at 0x07, month at 0x08, year at 0x09 and century at 0x48. The status register is at 0x0A and the mode register at 0x0B. A byte written to a field can be read back one edge after the write. Any other address reads 0x00.
- R3: A tick edge taken while the freeze bit is 0 sets status bit 7 for exactly one cycle, and all fields advance on the next edge. A tick that arrives while the flag is set is ignored.
- R4: In BCD mode (mode bit 2 = 0), seconds count 00 to 59 and carry into minutes, and minutes count 00 to 59 and carry into hours.
- R5: In binary mode (mode bit 2 = 1), every field counts in plain binary over the same ranges, for example seconds 0x3B roll to 0x00.
- R6: In 24-hour mode (mode bit 1 = 1), hours count 00 to 23, and 23 rolls to 00 with a carry into the day fields.
- R7: In 12-hour mode (mode bit 1 = 0), hours count 1 to 12. The step from 11 to 12 toggles bit 7 (PM), and 12 rolls to 1 with bit 7 unchanged. Only the step from 11 PM to 12 AM carries into the day fields.
- R8: Day of month rolls to 01 after the last day of its month: 30 for April, June, September and November, 31 for the other long months, and 28 for February, or 29 when the year is divisible by 4.
- R9: Month 12 rolls to 01 and carries into the year. Year 99 rolls to 00 and carries into the century. Day of week counts 1 to 7 and wraps to 1 at each day carry.
- R10: While mode bit 7 (freeze) is 1, ticks cause no update and do not set the status flag. The first tick after the bit is cleared resumes counting from the written values.
- R11: Each write keeps only the bits the current mode gives the field; for example 0xFF written to seconds reads 0x7F in BCD and 0x3F in binary, and 0xFF written to hours in 12-hour BCD reads 0x9F. The mode register keeps only bits 7, 2 and 1. The status register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 7 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |

## Verification
A host write is visible on the port after the edge that takes it. The status flag rises one edge after a tick is taken. The advanced field values appear on the edge after that, with the flag cleared in the same cycle. The bench keeps a behavioural model that steps at every rising edge. Just after each edge it reads every mapped address and compares the result with the model, and all directed checks sample in the cycle these timings predict, after the edge and before the next falling edge.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int DW   = 8;
  localparam int AW   = 7;
  localparam int NFLD = 8;

  typedef logic [DW-1:0] byte_t;

  localparam int FI_SEC  = 0;
  localparam int FI_MIN  = 1;
  localparam int FI_HOUR = 2;
  localparam int FI_WDAY = 3;
  localparam int FI_MDAY = 4;
  localparam int FI_MON  = 5;
  localparam int FI_YEAR = 6;
  localparam int FI_CENT = 7;

  localparam logic [AW-1:0] FLD_ADDR [NFLD] =
    '{7'h00, 7'h02, 7'h04, 7'h06, 7'h07, 7'h08, 7'h09, 7'h48};
  localparam logic [AW-1:0] A_STAT = 7'h0A;
  localparam logic [AW-1:0] A_MODE = 7'h0B;

  // encode a small integer in the selected number format
  function automatic byte_t f_enc(int unsigned v, logic bcd);
    if (bcd) return byte_t'(((v / 10) << 4) | (v % 10));
    return byte_t'(v);
  endfunction

  // add one in the selected format
  function automatic byte_t f_inc(byte_t b, logic bcd);
    if (bcd && (b[3:0] >= 4'd9)) return {b[7:4] + 4'd1, 4'd0};
    return b + 8'd1;
  endfunction

  function automatic byte_t f_to_bin(byte_t b, logic bcd);
    if (bcd) return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    return b;
  endfunction

  // year divisible by four, in either format
  function automatic logic f_leap(byte_t y, logic bcd);
    logic [1:0] r;
    r = bcd ? ({y[4], 1'b0} + y[1:0]) : y[1:0];
    return (r == 2'd0);
  endfunction

  function automatic byte_t f_mask(int unsigned idx, logic bcd, logic h24);
    case (idx)
      FI_SEC, FI_MIN: return bcd ? 8'h7f : 8'h3f;
      FI_HOUR:        return h24 ? (bcd ? 8'h3f : 8'h1f) : (bcd ? 8'h9f : 8'h8f);
      FI_WDAY:        return 8'h07;
      FI_MDAY:        return bcd ? 8'h3f : 8'h1f;
      FI_MON:         return bcd ? 8'h1f : 8'h0f;
      default:        return bcd ? 8'hff : 8'h7f;
    endcase
  endfunction

  function automatic byte_t f_rst(int unsigned idx);
    case (idx)
      FI_HOUR:                 return 8'h12;
      FI_WDAY, FI_MDAY, FI_MON: return 8'h01;
      FI_CENT:                 return 8'h20;
      default:                 return 8'h00;
    endcase
  endfunction

  function automatic byte_t f_lo(int unsigned idx, logic bcd);
    case (idx)
      FI_WDAY, FI_MDAY, FI_MON: return f_enc(1, bcd);
      default:                  return f_enc(0, bcd);
    endcase
  endfunction

  function automatic byte_t f_hi(int unsigned idx, logic bcd);
    case (idx)
      FI_SEC, FI_MIN:   return f_enc(59, bcd);
      FI_WDAY:          return f_enc(7, bcd);
      FI_MON:           return f_enc(12, bcd);
      FI_YEAR, FI_CENT: return f_enc(99, bcd);
      default:          return f_enc(31, bcd);
    endcase
  endfunction
endpackage

// File: rtl/cal_wrap_ctr.sv
`timescale 1ns/1ps
module cal_wrap_ctr
  import rtc_cal_pkg::*;
(
  input  logic  step_i,
  input  logic  bcd_i,
  input  byte_t val_i,
  input  byte_t lo_i,
  input  byte_t hi_i,
  output byte_t nxt_o,
  output logic  wrap_o
);
  always_comb begin
    nxt_o  = val_i;
    wrap_o = 1'b0;
    if (step_i) begin
      if (val_i >= hi_i) begin
        nxt_o  = lo_i;
        wrap_o = 1'b1;
      end else begin
        nxt_o = f_inc(val_i, bcd_i);
      end
    end
  end
endmodule

// File: rtl/cal_hour_ctr.sv
`timescale 1ns/1ps
module cal_hour_ctr
  import rtc_cal_pkg::*;
(
  input  logic  step_i,
  input  logic  bcd_i,
  input  logic  h24_i,
  input  byte_t val_i,
  output byte_t nxt_o,
  output logic  day_o
);
  byte_t hr, e01, e11, e12, e23;
  logic  pm;

  always_comb begin
    pm    = val_i[7];
    hr    = val_i & (bcd_i ? 8'h1f : 8'h0f);
    e01   = f_enc(1, bcd_i);
    e11   = f_enc(11, bcd_i);
    e12   = f_enc(12, bcd_i);
    e23   = f_enc(23, bcd_i);
    nxt_o = val_i;
    day_o = 1'b0;
    if (step_i) begin
      if (h24_i) begin
        if (val_i >= e23) begin
          nxt_o = 8'h00;
          day_o = 1'b1;
        end else begin
          nxt_o = f_inc(val_i, bcd_i);
        end
      end else if (hr >= e12) begin
        nxt_o = {pm, 7'b0} | e01;
      end else if (hr == e11) begin
        nxt_o = {~pm, 7'b0} | e12;
        day_o = pm;
      end else begin
        nxt_o = {pm, 7'b0} | f_inc(hr, bcd_i);
      end
    end
  end
endmodule

// File: rtl/cal_ctrl.sv
`timescale 1ns/1ps
module cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    wmode_i,
  output logic          set_o,
  output logic          bcd_o,
  output logic          h24_o,
  output logic          uip_o,
  output logic          upd_o
);
  // mode_q = {freeze, binary, 24-hour}
  logic [2:0] mode_q, mode_d;
  logic       pend_q, pend_d;

  always_comb begin
    mode_d = mode_q;
    if (we_i && (addr_i == A_MODE)) mode_d = wmode_i;
    pend_d = tick_i && !mode_q[2] && !pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 3'b000;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign set_o = mode_q[2];
  assign bcd_o = ~mode_q[1];
  assign h24_o = mode_q[0];
  assign uip_o = pend_q;
  assign upd_o = pend_q && !mode_q[2];
endmodule

// File: rtl/cal_field_regs.sv
`timescale 1ns/1ps
module cal_field_regs
  import rtc_cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  byte_t         nxt_i [NFLD],
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         wdata_i,
  input  logic          bcd_i,
  input  logic          h24_i,
  output byte_t         fld_o [NFLD]
);
  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    logic  hit;
    byte_t d, q;

    assign hit = we_i && (addr_i == FLD_ADDR[i]);

    always_comb begin
      d = q;
      if (hit)        d = wdata_i & f_mask(i, bcd_i, h24_i);
      else if (upd_i) d = nxt_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= f_rst(i);
      else         q <= d;
    end

    assign fld_o[i] = q;
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sec_tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic  mode_set, mode_bcd, mode_h24, uip, upd;
  byte_t fld_q [NFLD];
  byte_t nxt   [NFLD];
  logic  step  [NFLD];
  logic  wrap  [NFLD];
  byte_t mon_bin, mday_hi;
  logic  unused_wrap;

  cal_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sec_tick_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wmode_i ({wdata_i[7], wdata_i[2], wdata_i[1]}),
    .set_o   (mode_set),
    .bcd_o   (mode_bcd),
    .h24_o   (mode_h24),
    .uip_o   (uip),
    .upd_o   (upd)
  );

  cal_field_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .nxt_i   (nxt),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .bcd_i   (mode_bcd),
    .h24_i   (mode_h24),
    .fld_o   (fld_q)
  );

  // last day of the current month, in the current format
  always_comb begin
    mon_bin = f_to_bin(fld_q[FI_MON], mode_bcd);
    case (mon_bin)
      8'd2:                   mday_hi = f_leap(fld_q[FI_YEAR], mode_bcd) ?
                                        f_enc(29, mode_bcd) : f_enc(28, mode_bcd);
      8'd4, 8'd6, 8'd9, 8'd11: mday_hi = f_enc(30, mode_bcd);
      default:                mday_hi = f_enc(31, mode_bcd);
    endcase
  end

  // carry chain
  assign step[FI_SEC]  = upd;
  assign step[FI_MIN]  = wrap[FI_SEC];
  assign step[FI_HOUR] = wrap[FI_MIN];
  assign step[FI_WDAY] = wrap[FI_HOUR];
  assign step[FI_MDAY] = wrap[FI_HOUR];
  assign step[FI_MON]  = wrap[FI_MDAY];
  assign step[FI_YEAR] = wrap[FI_MON];
  assign step[FI_CENT] = wrap[FI_YEAR];
  assign unused_wrap   = wrap[FI_WDAY] ^ wrap[FI_CENT];

  for (genvar i = 0; i < NFLD; i++) begin : g_cnt
    if (i == FI_HOUR) begin : g_hr
      cal_hour_ctr u_hr (
        .step_i (step[i]),
        .bcd_i  (mode_bcd),
        .h24_i  (mode_h24),
        .val_i  (fld_q[i]),
        .nxt_o  (nxt[i]),
        .day_o  (wrap[i])
      );
    end else begin : g_gen
      cal_wrap_ctr u_ctr (
        .step_i (step[i]),
        .bcd_i  (mode_bcd),
        .val_i  (fld_q[i]),
        .lo_i   (f_lo(i, mode_bcd)),
        .hi_i   ((i == FI_MDAY) ? mday_hi : f_hi(i, mode_bcd)),
        .nxt_o  (nxt[i]),
        .wrap_o (wrap[i])
      );
    end
  end

  // host read port
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NFLD; i++) begin
      if (addr_i == FLD_ADDR[i]) rdata_o = fld_q[i];
    end
    if (addr_i == A_STAT) rdata_o = {uip, 7'b0};
    if (addr_i == A_MODE) rdata_o = {mode_set, 4'b0, ~mode_bcd, mode_h24, 1'b0};
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       we_i,
  input logic [6:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       uip,
  input logic       set,
  input logic       upd,
  input logic [7:0] sec,
  input logic [7:0] min
);
  logic sec_wr, min_wr;
  assign sec_wr = we_i && (addr_i == 7'h00);
  assign min_wr = we_i && (addr_i == 7'h02);

  a_r3_uip_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uip |=> !uip);

  a_r3_uip_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uip) |-> $past(tick_i));

  a_r10_freeze_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> !uip);

  a_r4_sec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd && !sec_wr) |=> $stable(sec));

  a_r4_sec_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !sec_wr) |=> !$stable(sec));

  a_r4_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd && !min_wr) |=> $stable(min));

  a_r11_mode_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 7'h0B) |-> ((rdata_o[6:3] == 4'h0) && !rdata_o[0]));

  a_r11_stat_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 7'h0A) |-> (rdata_o[6:0] == 7'h00));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (sec_tick_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .uip     (uip),
  .set     (mode_set),
  .upd     (upd),
  .sec     (fld_q[0]),
  .min     (fld_q[1])
);

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [6:0] addr = 7'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  rtc_calendar u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sec_tick_i (tick),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata)
  );

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;
  string req   = "R1";

  // ---------------- behavioural reference ----------------
  int m_raw [8];
  bit m_set, m_dm, m_h24, m_pend;
  int fld_addr [8] = '{'h00, 'h02, 'h04, 'h06, 'h07, 'h08, 'h09, 'h48};
  int sweep [10]   = '{'h00, 'h02, 'h04, 'h06, 'h07, 'h08, 'h09, 'h48, 'h0A, 'h0B};

  function automatic int dec(int b);
    return m_dm ? b : ((b >> 4) * 10 + (b & 15));
  endfunction

  function automatic int enc(int v);
    return m_dm ? v : (((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mmask(int i);
    case (i)
      0, 1:    return m_dm ? 'h3f : 'h7f;
      2:       return m_h24 ? (m_dm ? 'h1f : 'h3f) : (m_dm ? 'h8f : 'h9f);
      3:       return 'h07;
      4:       return m_dm ? 'h1f : 'h3f;
      5:       return m_dm ? 'h0f : 'h1f;
      default: return m_dm ? 'h7f : 'hff;
    endcase
  endfunction

  function automatic void m_reset();
    m_raw = '{'h00, 'h00, 'h12, 'h01, 'h01, 'h01, 'h00, 'h20};
    m_set = 0; m_dm = 0; m_h24 = 0; m_pend = 0;
  endfunction

  function automatic void advance();
    int v, pm, len, mo, yr;
    v = dec(m_raw[0]);
    if (v < 59) begin m_raw[0] = enc(v + 1); return; end
    m_raw[0] = enc(0);
    v = dec(m_raw[1]);
    if (v < 59) begin m_raw[1] = enc(v + 1); return; end
    m_raw[1] = enc(0);
    if (m_h24) begin
      v = dec(m_raw[2]);
      if (v < 23) begin m_raw[2] = enc(v + 1); return; end
      m_raw[2] = enc(0);
    end else begin
      pm = (m_raw[2] >> 7) & 1;
      v  = dec(m_raw[2] & 'h7f);
      if (v >= 12) begin m_raw[2] = (pm << 7) | enc(1); return; end
      if (v != 11) begin m_raw[2] = (pm << 7) | enc(v + 1); return; end
      m_raw[2] = ((1 - pm) << 7) | enc(12);
      if (pm == 0) return;
    end
    v = dec(m_raw[3]);
    m_raw[3] = enc(v >= 7 ? 1 : v + 1);
    mo = dec(m_raw[5]);
    yr = dec(m_raw[6]);
    if (mo == 2) len = (yr % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) len = 30;
    else len = 31;
    v = dec(m_raw[4]);
    if (v < len) begin m_raw[4] = enc(v + 1); return; end
    m_raw[4] = enc(1);
    if (mo < 12) begin m_raw[5] = enc(mo + 1); return; end
    m_raw[5] = enc(1);
    if (yr < 99) begin m_raw[6] = enc(yr + 1); return; end
    m_raw[6] = enc(0);
    v = dec(m_raw[7]);
    m_raw[7] = enc(v >= 99 ? 0 : v + 1);
  endfunction

  function automatic void m_step(bit tk, bit w, int a, int d);
    bit upd, np;
    upd = m_pend && !m_set;
    np  = tk && !m_set && !m_pend;
    if (upd) advance();
    if (w) begin
      for (int i = 0; i < 8; i++) if (a == fld_addr[i]) m_raw[i] = d & mmask(i);
      if (a == 'h0B) begin
        m_set = d[7]; m_dm = d[2]; m_h24 = d[1];
      end
    end
    m_pend = np;
  endfunction

  function automatic int m_read(int a);
    for (int i = 0; i < 8; i++) if (a == fld_addr[i]) return m_raw[i];
    if (a == 'h0A) return m_pend ? 'h80 : 0;
    if (a == 'h0B) return (m_set << 7) | (m_dm << 2) | (m_h24 << 1);
    return 0;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(logic [7:0] got, logic [7:0] exp, string tag, string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(bit tk, bit w, logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    tick = tk; we = w; addr = a; wdata = d;
    @(posedge clk);
    m_step(tk, w, a, d);
    #1;
    tick = 0; we = 0;
    for (int k = 0; k < 10; k++) begin
      addr = 7'(sweep[k]);
      #0.2;
      chk(rdata, 8'(m_read(sweep[k])), req, $sformatf("model reg %02h", sweep[k]));
    end
  endtask

  task automatic look(logic [6:0] a, logic [7:0] e, string tag);
    addr = a;
    #0.2;
    chk(rdata, e, tag, $sformatf("reg %02h", a));
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    cyc(0, 1, a, d);
  endtask

  task automatic idle();
    cyc(0, 0, 7'h00, 8'h00);
  endtask

  task automatic do_tick();
    cyc(1, 0, 7'h00, 8'h00);
    idle();
  endtask

  // load 23:59:59 or 11:59:59 PM and a date, then run
  task automatic load(logic [7:0] frz, logic [7:0] run, logic [7:0] s, logic [7:0] m,
                      logic [7:0] h, logic [7:0] md, logic [7:0] mo, logic [7:0] yr);
    wr(7'h0B, frz);
    wr(7'h00, s); wr(7'h02, m); wr(7'h04, h);
    wr(7'h07, md); wr(7'h08, mo); wr(7'h09, yr);
    wr(7'h0B, run);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_err++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    req = "R1";
    idle();
    look(7'h00, 8'h00, "R1"); look(7'h02, 8'h00, "R1"); look(7'h04, 8'h12, "R1");
    look(7'h06, 8'h01, "R1"); look(7'h48, 8'h20, "R1");
    idle();
    look(7'h07, 8'h01, "R1"); look(7'h08, 8'h01, "R1"); look(7'h09, 8'h00, "R1");
    look(7'h0A, 8'h00, "R1"); look(7'h0B, 8'h00, "R1");

    // R2 and R11: map, masking, ignored writes
    req = "R11";
    wr(7'h00, 8'hFF);  look(7'h00, 8'h7F, "R11");
    wr(7'h04, 8'hFF);  look(7'h04, 8'h9F, "R11");
    wr(7'h0A, 8'hFF);  look(7'h0A, 8'h00, "R11");
    wr(7'h0B, 8'h7F);  look(7'h0B, 8'h06, "R11");
    wr(7'h0B, 8'h00);  wr(7'h00, 8'h00); wr(7'h04, 8'h12);
    req = "R2";
    wr(7'h48, 8'h19);  look(7'h48, 8'h19, "R2");
    wr(7'h30, 8'h55);  look(7'h30, 8'h00, "R2");
    look(7'h01, 8'h00, "R2");

    // R10 freeze, then R3 timing, R4 and R9 full carry
    req = "R10";
    load(8'h80, 8'h80, 8'h58, 8'h59, 8'h91, 8'h31, 8'h12, 8'h99);
    wr(7'h06, 8'h07); wr(7'h48, 8'h20);
    cyc(1, 0, 7'h00, 8'h00);
    look(7'h0A, 8'h00, "R10");
    idle();
    look(7'h00, 8'h58, "R10");
    wr(7'h0B, 8'h00);
    req = "R3";
    cyc(1, 0, 7'h00, 8'h00);
    look(7'h0A, 8'h80, "R3"); look(7'h00, 8'h58, "R3");
    idle();
    look(7'h00, 8'h59, "R3"); look(7'h0A, 8'h00, "R3");
    req = "R9";
    cyc(1, 0, 7'h00, 8'h00);
    cyc(1, 0, 7'h00, 8'h00);   // second tick lands while the flag is set
    look(7'h00, 8'h00, "R4"); look(7'h02, 8'h00, "R4"); look(7'h04, 8'h12, "R7");
    idle();
    look(7'h06, 8'h01, "R9"); look(7'h07, 8'h01, "R8"); look(7'h08, 8'h01, "R9");
    look(7'h09, 8'h00, "R9"); look(7'h48, 8'h21, "R9");
    idle(); idle();
    look(7'h00, 8'h00, "R3");

    // R7 12-hour
    req = "R7";
    load(8'h80, 8'h00, 8'h59, 8'h59, 8'h11, 8'h05, 8'h03, 8'h10);
    do_tick();
    look(7'h04, 8'h92, "R7"); look(7'h07, 8'h05, "R7");
    load(8'h80, 8'h00, 8'h59, 8'h59, 8'h92, 8'h05, 8'h03, 8'h10);
    do_tick();
    look(7'h04, 8'h81, "R7"); look(7'h07, 8'h05, "R7");

    // R6 24-hour
    req = "R6";
    load(8'h82, 8'h02, 8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h10);
    wr(7'h06, 8'h03);
    do_tick();
    look(7'h04, 8'h00, "R6"); look(7'h06, 8'h04, "R6"); look(7'h07, 8'h16, "R6");

    // R8 month lengths and leap years
    req = "R8";
    load(8'h82, 8'h02, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
    do_tick(); look(7'h07, 8'h01, "R8"); look(7'h08, 8'h03, "R8");
    load(8'h82, 8'h02, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
    do_tick(); look(7'h07, 8'h29, "R8"); look(7'h08, 8'h02, "R8");
    load(8'h82, 8'h02, 8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24);
    do_tick(); look(7'h07, 8'h01, "R8"); look(7'h08, 8'h03, "R8");
    load(8'h82, 8'h02, 8'h59, 8'h59, 8'h23, 8'h29, 8'h04, 8'h24);
    do_tick(); look(7'h07, 8'h30, "R8");
    load(8'h82, 8'h02, 8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h24);
    do_tick(); look(7'h07, 8'h01, "R8"); look(7'h08, 8'h05, "R8");
    load(8'h82, 8'h02, 8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h24);
    do_tick(); look(7'h07, 8'h01, "R8"); look(7'h08, 8'h02, "R8");

    // R5 binary counting
    req = "R5";
    load(8'h86, 8'h06, 8'h3A, 8'h3B, 8'h17, 8'h1C, 8'h02, 8'h18);
    do_tick(); look(7'h00, 8'h3B, "R5");
    do_tick();
    look(7'h00, 8'h00, "R5"); look(7'h02, 8'h00, "R5"); look(7'h04, 8'h00, "R5");
    look(7'h07, 8'h1D, "R5");
    req = "R11";
    wr(7'h00, 8'hFF); look(7'h00, 8'h3F, "R11");
    do_tick(); look(7'h00, 8'h00, "R5");

    idle();
    finish_run();
  end
endmodule